// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the bit timing for an asynchronous serial shifter. A 16-bit divisor, supplied as a high byte and a low byte, sets the nominal number of source-clock periods per bit. An 8-bit modulation pattern can stretch selected bits by one source period. Each bit of a frame takes the next pattern bit in turn, so the average bit length comes close to a fractional divisor. With this scheme a slow crystal, for example 32768 Hz, can reach common baud rates with little error accumulated over a frame.

The counting source is picked by a 2-bit select from three source-clock enables, all qualified on the single system clock. A frame-start strobe begins timing at the first pattern bit. While the shifter holds its advance input high, the generator moves on from bit to bit. When the advance input is low at the end of a bit, the generator stops. It drives a bit clock whose halves split the bit period, together with single-cycle mid-bit and end-of-bit ticks.

Top module: `frac_baud_gen`

## Requirements
- R1: The source select picks the counting enable: 0 takes the external enable, 1 takes the auxiliary enable, and 2 or 3 take the main enable. Only enabled system-clock edges advance the bit timing.
- R2: Bit number i of a frame lasts D + p[i mod 8] counted source enables, where D is the divisor and p is the modulation pattern. The pattern and the divisor are never altered by the block.
- R3: Pattern bit 0 times the first bit after a frame start, pattern bit 1 the next, and so on. After pattern bit 7 the sequence wraps to pattern bit 0.
- R4: For a bit of n counted enables, the bit clock is low for the first floor(n/2) enables and high for the remaining n - floor(n/2). A mid-bit tick is pulsed when the bit clock rises and an end-of-bit tick when the bit ends, with the bit clock low at that point.
- R5: The divisor is the 16-bit value {high byte, low byte}.
- R6: A divisor below 3 produces no ticks, and the bit clock stays low.
- R7: If the advance input is low when a bit ends, the generator goes idle. It then produces no further ticks until the next frame start.
- R8: A frame start during a running frame discards the current bit. Timing restarts from zero count at pattern bit 0.
- R9: After reset the bit clock and both ticks are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Counting source select |
| ext_en | input | 1 | External source-clock enable |
| aux_en | input | 1 | Low-frequency auxiliary source-clock enable |
| main_en | input | 1 | Main source-clock enable |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| mod_pat | input | 8 | Modulation pattern, bit 0 used first |
| frame_start | input | 1 | Starts a frame at pattern bit 0 |
| bit_adv | input | 1 | Continue with the next bit when high at a bit end |
| bit_clk | output | 1 | Bit clock, low then high within each bit |
| mid_tick | output | 1 | One-cycle pulse at the bit-clock rise |
| end_tick | output | 1 | One-cycle pulse at the end of each bit |

## Verification
All three outputs are registered. With the main source enabled every cycle, a frame start taken at edge E0 makes the first mid-bit tick visible floor(n/2) cycles later and the first end tick n cycles later. Each later bit ends n_i cycles after the previous end tick. The bench keeps a cycle counter, reads the outputs on the falling edge, and compares the tick times against the sums it computes from the divisor and pattern. With the slower enables, intervals grow by the enable spacing, and the first bit, which depends on phase, is not timed.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT      = 2'd0,
    SRC_AUX      = 2'd1,
    SRC_MAIN     = 2'd2,
    SRC_MAIN_ALT = 2'd3
  } src_sel_e;
endpackage

// File: rtl/fbrg_src_mux.sv
module fbrg_src_mux
  import fbrg_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_en,
  input  logic             aux_en,
  input  logic             main_en,
  output logic             src_en
);
  src_sel_e sel_e;

  always_comb begin
    sel_e = src_sel_e'(sel);
    unique case (sel_e)
      SRC_EXT:      src_en = ext_en;
      SRC_AUX:      src_en = aux_en;
      SRC_MAIN,
      SRC_MAIN_ALT: src_en = main_en;
      default:      src_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/fbrg_period_sel.sv
module fbrg_period_sel #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned MOD_W   = 8,
  parameter int unsigned MIN_DIV = 3,
  localparam int unsigned IDX_W  = $clog2(MOD_W),
  localparam int unsigned CNT_W  = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [MOD_W-1:0] mod_pat,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] half,
  output logic             div_ok
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MOD_W - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (restart) begin
      idx_d = '0;
    end else if (advance) begin
      idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (restart || advance) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    div_ok = ({1'b0, div} >= CNT_W'(MIN_DIV));
    period = {1'b0, div} + CNT_W'(mod_pat[idx_q]);
    half   = period >> 1;
  end

  // R3: pattern index steps by one and wraps after the last bit
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(advance) && !$past(restart)) |->
      (idx_q == (($past(idx_q) == IDX_LAST) ? '0 : $past(idx_q) + 1'b1)));

  // R8: a frame start always returns to pattern bit 0
  a_r8_restart_index: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (idx_q == '0));
endmodule

// File: rtl/fbrg_bit_timer.sv
module fbrg_bit_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic             start,
  input  logic             keep_going,
  input  logic             div_ok,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] half,
  output logic             advance,
  output logic             bit_clk,
  output logic             mid_tick,
  output logic             end_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             act_q, act_d;
  logic             bclk_q, bclk_d;
  logic             mid_q, mid_d;
  logic             end_q, end_d;
  logic             hit_end;
  logic             step;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    step    = act_q && src_en;
    cnt_d   = cnt_q;
    act_d   = act_q;
    bclk_d  = bclk_q;
    mid_d   = 1'b0;
    end_d   = 1'b0;
    hit_end = 1'b0;
    if (start) begin
      cnt_d  = '0;
      act_d  = div_ok;
      bclk_d = 1'b0;
    end else if (!div_ok) begin
      cnt_d  = '0;
      act_d  = 1'b0;
      bclk_d = 1'b0;
    end else if (step) begin
      if (cnt_inc == half) begin
        mid_d  = 1'b1;
        bclk_d = 1'b1;
      end
      if (cnt_inc == period) begin
        end_d   = 1'b1;
        bclk_d  = 1'b0;
        cnt_d   = '0;
        hit_end = 1'b1;
        act_d   = keep_going;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  assign advance = hit_end && keep_going;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      bclk_q <= 1'b0;
      mid_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      bclk_q <= bclk_d;
      mid_q  <= mid_d;
      end_q  <= end_d;
    end
  end

  assign bit_clk  = bclk_q;
  assign mid_tick = mid_q;
  assign end_tick = end_q;

  // R4: the two ticks never coincide
  a_r4_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mid_q && end_q));

  // R2: the running count stays below the bit period
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < period));

  // R7: an idle timer emits no tick in the following cycle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act_q) |-> (!mid_q && !end_q));

  // R4: bit clock is high at the mid tick and low at the end tick
  a_r4_mid_high: assert property (@(posedge clk) disable iff (!rst_n)
    mid_q |-> bclk_q);
  a_r4_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !bclk_q);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbrg_pkg::*;
#(
  parameter int unsigned MOD_W   = 8,
  parameter int unsigned MIN_DIV = 3,
  localparam int unsigned DIV_W  = 2 * BYTE_W,
  localparam int unsigned CNT_W  = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              ext_en,
  input  logic              aux_en,
  input  logic              main_en,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [MOD_W-1:0]  mod_pat,
  input  logic              frame_start,
  input  logic              bit_adv,
  output logic              bit_clk,
  output logic              mid_tick,
  output logic              end_tick
);
  logic [DIV_W-1:0] div_word;
  logic             src_en;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;
  logic             div_ok;
  logic             advance;

  assign div_word = {div_hi, div_lo};

  fbrg_src_mux u_mux (
    .sel     (src_sel),
    .ext_en  (ext_en),
    .aux_en  (aux_en),
    .main_en (main_en),
    .src_en  (src_en)
  );

  fbrg_period_sel #(
    .DIV_W   (DIV_W),
    .MOD_W   (MOD_W),
    .MIN_DIV (MIN_DIV)
  ) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div_word),
    .mod_pat (mod_pat),
    .restart (frame_start),
    .advance (advance),
    .period  (period),
    .half    (half),
    .div_ok  (div_ok)
  );

  fbrg_bit_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .start      (frame_start),
    .keep_going (bit_adv),
    .div_ok     (div_ok),
    .period     (period),
    .half       (half),
    .advance    (advance),
    .bit_clk    (bit_clk),
    .mid_tick   (mid_tick),
    .end_tick   (end_tick)
  );

  // R6: a divisor under the minimum seen at an edge yields no tick after it
  a_r6_small_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_word) < DIV_W'(MIN_DIV)) |-> (!mid_tick && !end_tick));
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'd2;
  logic       ext_en, aux_en;
  logic       main_en = 1'b1;
  logic [15:0] div = 16'd5;
  logic [7:0] mod_pat = 8'h00;
  logic       frame_start = 1'b0;
  logic       bit_adv = 1'b0;
  logic       bit_clk, mid_tick, end_tick;

  int checks = 0;
  int fails = 0;
  longint cyc = 0;
  int ph2 = 0;
  int ph3 = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    ph2 <= (ph2 + 1) % 2;
    ph3 <= (ph3 + 1) % 3;
  end
  assign ext_en = (ph2 == 0);
  assign aux_en = (ph3 == 0);

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .ext_en(ext_en), .aux_en(aux_en), .main_en(main_en),
    .div_hi(div[15:8]), .div_lo(div[7:0]), .mod_pat(mod_pat),
    .frame_start(frame_start), .bit_adv(bit_adv),
    .bit_clk(bit_clk), .mid_tick(mid_tick), .end_tick(end_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(output longint t0);
    @(negedge clk);
    frame_start = 1'b1;
    bit_adv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_tick(input bit want_mid, input int limit, output longint t, output bit ok);
    ok = 1'b0;
    t = 0;
    for (int w = 0; w < limit; w++) begin
      @(negedge clk);
      if (want_mid ? mid_tick : end_tick) begin
        ok = 1'b1;
        t = cyc;
        break;
      end
    end
  endtask

  // Times nbits bits from start0; k is the spacing of the chosen enable.
  task automatic measure(input string req, input longint start0, input int nbits,
                         input int k, input bit stop);
    longint st, tm, te;
    bit ok;
    int n, h, quiet;
    st = start0;
    for (int b = 0; b < nbits; b++) begin
      n = int'(div) + int'(mod_pat[b % 8]);
      h = n / 2;
      wait_tick(1'b1, 4 * k * n + 10, tm, ok);
      chk(ok, {req, " mid tick seen"}, ok, 1);
      if (b > 0 || k == 1)
        chk(tm - st == longint'(k * h), {req, " R4 mid time"}, tm - st, k * h);
      chk(bit_clk == 1'b1, {req, " R4 bit_clk high at mid"}, bit_clk, 1);
      if (stop && b == nbits - 1) bit_adv = 1'b0;
      wait_tick(1'b0, 4 * k * n + 10, te, ok);
      chk(ok, {req, " end tick seen"}, ok, 1);
      if (b > 0 || k == 1)
        chk(te - st == longint'(k * n), (b >= 8) ? {req, " R3 wrapped period"} : {req, " R2 period"},
            te - st, k * n);
      chk(bit_clk == 1'b0, {req, " R4 bit_clk low at end"}, bit_clk, 0);
      st = te;
    end
    if (stop) begin
      quiet = 0;
      n = int'(div) + 1;
      for (int w = 0; w < 3 * k * n; w++) begin
        @(negedge clk);
        if (mid_tick || end_tick || bit_clk) quiet++;
      end
      chk(quiet == 0, {req, " R7 idle after stop"}, quiet, 0);
    end
  endtask

  task automatic t_reset;
    chk(bit_clk == 1'b0, "R9 bit_clk in reset", bit_clk, 0);
    chk(mid_tick == 1'b0 && end_tick == 1'b0, "R9 ticks in reset", {mid_tick, end_tick}, 0);
  endtask

  task automatic t_plain;
    longint t0;
    src_sel = 2'd2; div = 16'd5; mod_pat = 8'h00;
    kick(t0);
    measure("R2 plain div5", t0, 3, 1, 1'b1);
  endtask

  task automatic t_mod_ef;
    longint t0;
    src_sel = 2'd2; div = 16'd6; mod_pat = 8'hEF;
    kick(t0);
    measure("R3 pattern EF", t0, 11, 1, 1'b1);
  endtask

  task automatic t_mod_6d;
    longint t0;
    src_sel = 2'd2; div = 16'd13; mod_pat = 8'h6D;
    kick(t0);
    measure("R4 odd halves 6D", t0, 9, 1, 1'b1);
  endtask

  task automatic t_wide;
    longint t0;
    src_sel = 2'd2; div = 16'h0102; mod_pat = 8'h02;
    kick(t0);
    measure("R5 two-byte divisor", t0, 2, 1, 1'b1);
  endtask

  task automatic t_sources;
    longint t0;
    div = 16'd4; mod_pat = 8'h05;
    src_sel = 2'd0;
    kick(t0);
    measure("R1 external enable", t0, 4, 2, 1'b1);
    src_sel = 2'd1;
    kick(t0);
    measure("R1 auxiliary enable", t0, 4, 3, 1'b1);
    src_sel = 2'd3;
    kick(t0);
    measure("R1 main alt select", t0, 3, 1, 1'b1);
  endtask

  task automatic t_small;
    longint t0;
    int seen;
    src_sel = 2'd2; mod_pat = 8'hFF;
    div = 16'd2;
    kick(t0);
    seen = 0;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      if (mid_tick || end_tick || bit_clk) seen++;
    end
    chk(seen == 0, "R6 divisor 2 silent", seen, 0);
    bit_adv = 1'b0;
    div = 16'd3; mod_pat = 8'h00;
    kick(t0);
    measure("R6 divisor 3 runs", t0, 2, 1, 1'b1);
  endtask

  task automatic t_restart;
    longint t0;
    src_sel = 2'd2; div = 16'd7; mod_pat = 8'h01;
    kick(t0);
    measure("R8 before restart", t0, 2, 1, 1'b0);
    repeat (2) @(negedge clk);
    kick(t0);
    measure("R8 after restart", t0, 3, 1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_mod_ef();
    t_mod_6d();
    t_wide();
    t_sources();
    t_small();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule